// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called side A and side B, through two one-way transfer paths. Each path has its own storage register, its own capture clock, its own source select and its own output enable. A path drives its destination bus with either the live value on the opposite bus or the value it captured earlier. The data is complemented on the way through in both directions. The register in each path loads on every rising edge of its clock, whatever the select and enable inputs are doing. This lets a path hold a snapshot while its output is parked in high impedance, and present it later.

Each bidirectional pin group is split into three vectors: an input, an output and an output-enable. Logic outside the block resolves these onto the real shared wires. Both paths can be enabled at the same time with both selects on the live source. If nothing else then drives either bus, each bus keeps its value, because each side's output is the complement of the other side, which is itself the complement of the first. An active-low asynchronous reset clears both registers. The reset does not touch the output enables.

Top module: `xcvr_regbus`

## Requirements
- R1: While rst_n is low, both storage registers are cleared to all zeros. After reset, selecting the stored source on an enabled path drives all ones (8'hFF).
- R2: A rising edge on clk_a2b loads the value present on a_in into the A-to-B register.
- R3: A rising edge on clk_b2a loads the value present on b_in into the B-to-A register.
- R4: A load happens whatever the states of sel_a2b, sel_b2a, en_a2b and en_b2a_n. A value captured while both outputs are disabled appears later when the stored source is selected.
- R5: With en_a2b high, sel_a2b = 0 gives b_out = ~a_in, combinationally. sel_a2b = 1 gives b_out = ~(A-to-B register).
- R6: With en_b2a_n low, sel_b2a = 0 gives a_out = ~b_in, combinationally. sel_b2a = 1 gives a_out = ~(B-to-A register).
- R7: b_oe is high exactly when en_a2b is high. The enable is active high.
- R8: a_oe is high exactly when en_b2a_n is low. The enable is active low.
- R9: With both paths enabled and both selects at 0, and no outside driver on either bus, each bus keeps the value it had when the outside drive was released.
- R10: rst_n has no effect on a_oe or b_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both storage registers |
| clk_a2b | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_b2a | input | 1 | Capture clock of the B-to-A register (rising edge) |
| sel_a2b | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B value |
| sel_b2a | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A value |
| en_a2b | input | 1 | Active-high enable of the B-side driver |
| en_b2a_n | input | 1 | Active-low enable of the A-side driver |
| a_in | input | 8 | Resolved value seen on bus A |
| a_out | output | 8 | Value the block drives onto bus A (zero when disabled) |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | 8 | Resolved value seen on bus B |
| b_out | output | 8 | Value the block drives onto bus B (zero when disabled) |
| b_oe | output | 1 | Bus B driver enable |

## Verification
The bench targets a capture made with both drivers parked. A design that gated the load with the enable or the select would later present the reset value instead of the snapshot. It swaps the live input after a capture. A stored path that leaked the live bus, or a missing inversion, then shows a value off by the new input or by its complement. It exercises both enable polarities in the same run, so swapped senses show up as a driven bus where high impedance was expected. It also closes the two-path hold loop by releasing the outside driver. A wrong inversion or a wrong select on either side would flip the bus or lose the value, where the correct design keeps it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Loads on every rising edge; no enable by design.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_drive_path.sv
module xcvr_drive_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         [W-1:0] live,
  input  logic         [W-1:0] stored,
  input  src_sel_e             sel,
  input  logic                 drive_en,
  output logic         [W-1:0] pin_out,
  output logic                 pin_oe
);
  logic [W-1:0] chosen;

  always_comb begin
    chosen  = (sel == SRC_STORED) ? stored : live;
    pin_oe  = drive_en;
    pin_out = drive_en ? ~chosen : '0;
  end
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
  import xcvr_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         rst_n,
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         en_a2b,
  input  logic         en_b2a_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int unsigned NDIR = 2;  // index 0: A->B, index 1: B->A

  logic [NDIR-1:0]        cap_clk;
  logic [NDIR-1:0]        drv_en;
  src_sel_e               src   [NDIR];
  logic [W-1:0]           srcv  [NDIR];
  logic [W-1:0]           held  [NDIR];
  logic [W-1:0]           dout  [NDIR];
  logic [NDIR-1:0]        doe;

  always_comb begin
    cap_clk = {clk_b2a, clk_a2b};
    drv_en  = {~en_b2a_n, en_a2b};
    src[0]  = src_sel_e'(sel_a2b);
    src[1]  = src_sel_e'(sel_b2a);
    srcv[0] = a_in;
    srcv[1] = b_in;
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcvr_store_reg #(.W(W)) u_reg (
      .clk   (cap_clk[g]),
      .rst_n (rst_n),
      .d     (srcv[g]),
      .q     (held[g])
    );
    xcvr_drive_path #(.W(W)) u_path (
      .live     (srcv[g]),
      .stored   (held[g]),
      .sel      (src[g]),
      .drive_en (drv_en[g]),
      .pin_out  (dout[g]),
      .pin_oe   (doe[g])
    );
  end

  assign b_out = dout[0];
  assign b_oe  = doe[0];
  assign a_out = dout[1];
  assign a_oe  = doe[1];
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_n,
  input logic         clk_a2b,
  input logic         clk_b2a,
  input logic         sel_a2b,
  input logic         sel_b2a,
  input logic         en_a2b,
  input logic         en_b2a_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  // R2
  a2b_stored_chk: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (sel_a2b && en_a2b && $past(rst_n)) |-> (b_out == ~$past(a_in)));

  // R3
  b2a_stored_chk: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    (sel_b2a && !en_b2a_n && $past(rst_n)) |-> (a_out == ~$past(b_in)));

  // R5
  a2b_live_chk: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    (!sel_a2b && en_a2b) |-> (b_out == ~a_in));

  // R6
  b2a_live_chk: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    (!sel_b2a && !en_b2a_n) |-> (a_out == ~b_in));

  // R7
  b_enable_chk: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    b_oe == en_a2b);

  // R8
  a_enable_chk: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    a_oe == !en_b2a_n);
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W)) u_chk (
  .rst_n    (rst_n),
  .clk_a2b  (clk_a2b),
  .clk_b2a  (clk_b2a),
  .sel_a2b  (sel_a2b),
  .sel_b2a  (sel_b2a),
  .en_a2b   (en_a2b),
  .en_b2a_n (en_b2a_n),
  .a_in     (a_in),
  .a_out    (a_out),
  .a_oe     (a_oe),
  .b_in     (b_in),
  .b_out    (b_out),
  .b_oe     (b_oe)
);

// File: tb/test_xcvr_regbus.sv
`timescale 1ns/1ps
module test_xcvr_regbus;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_a2b = 1'b0, clk_b2a = 1'b0;
  logic         sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic         en_a2b = 1'b0, en_b2a_n = 1'b1;
  logic [W-1:0] a_bus = '0, b_bus = '0;
  logic [W-1:0] a_ext = '0, b_ext = '0;
  logic         a_ext_en = 1'b0, b_ext_en = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  int           n_cmp = 0, n_bad = 0, n_clash = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  xcvr_regbus #(.W(W)) i_xcvr_regbus (
    .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .en_a2b(en_a2b), .en_b2a_n(en_b2a_n),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
  );

  // Resolve both shared wires; an undriven wire keeps its value.
  task automatic settle();
    for (int i = 0; i < 6; i++) begin
      #0.2;
      if (a_oe && a_ext_en) n_clash++;
      if (b_oe && b_ext_en) n_clash++;
      a_bus = a_oe ? a_out : (a_ext_en ? a_ext : a_bus);
      b_bus = b_oe ? b_out : (b_ext_en ? b_ext : b_bus);
    end
  endtask

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_a2b();
    settle();
    @(negedge clk); clk_a2b = 1'b1;
    @(negedge clk); clk_a2b = 1'b0;
    settle();
  endtask

  task automatic pulse_b2a();
    settle();
    @(negedge clk); clk_b2a = 1'b1;
    @(negedge clk); clk_b2a = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    en_a2b = 1'b1; en_b2a_n = 1'b0; sel_a2b = 1'b1; sel_b2a = 1'b1;
    settle();
    // R10: enables act while reset is held
    check("R10 b_oe in reset", {7'b0, b_oe}, 8'h01);
    check("R10 a_oe in reset", {7'b0, a_oe}, 8'h01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: cleared registers give all ones through the inversion
    check("R1 b_out stored after reset", b_out, 8'hFF);
    check("R1 a_out stored after reset", a_out, 8'hFF);
  endtask

  task automatic t_a2b_live();
    en_b2a_n = 1'b1; en_a2b = 1'b1; sel_a2b = 1'b0;
    a_ext_en = 1'b1; a_ext = 8'h3C; settle();
    check("R8 a_oe off", {7'b0, a_oe}, 8'h00);
    check("R5 live 3C", b_out, 8'hC3);
    a_ext = 8'hA5; settle();
    check("R5 live A5", b_out, 8'h5A);
    check("R5 bus B", b_bus, 8'h5A);
  endtask

  task automatic t_a2b_stored();
    a_ext = 8'h96; pulse_a2b();
    a_ext = 8'h11; sel_a2b = 1'b1; settle();
    check("R2 stored 96", b_out, 8'h69);
    sel_a2b = 1'b0; settle();
    check("R5 back to live 11", b_out, 8'hEE);
  endtask

  task automatic t_b2a();
    en_a2b = 1'b0; a_ext_en = 1'b0; settle();
    check("R7 b_oe off", {7'b0, b_oe}, 8'h00);
    b_ext_en = 1'b1; b_ext = 8'h5A; en_b2a_n = 1'b0; sel_b2a = 1'b0; settle();
    check("R6 live 5A", a_out, 8'hA5);
    b_ext = 8'h0F; pulse_b2a();
    b_ext = 8'hC7; sel_b2a = 1'b1; settle();
    check("R3 stored 0F", a_out, 8'hF0);
    check("R6 bus A stored", a_bus, 8'hF0);
  endtask

  task automatic t_capture_parked();
    en_a2b = 1'b0; en_b2a_n = 1'b1; settle();
    check("R7 b_oe parked", {7'b0, b_oe}, 8'h00);
    check("R8 a_oe parked", {7'b0, a_oe}, 8'h00);
    a_ext_en = 1'b1; a_ext = 8'h77; sel_a2b = 1'b0; pulse_a2b();
    b_ext_en = 1'b1; b_ext = 8'hE1; sel_b2a = 1'b0; pulse_b2a();
    b_ext_en = 1'b0; sel_a2b = 1'b1; a_ext = 8'h00; en_a2b = 1'b1; settle();
    check("R4 A->B parked capture", b_out, 8'h88);
    en_a2b = 1'b0; a_ext_en = 1'b0; sel_b2a = 1'b1; en_b2a_n = 1'b0; settle();
    check("R4 B->A parked capture", a_out, 8'h1E);
  endtask

  task automatic t_hold();
    en_b2a_n = 1'b1; sel_a2b = 1'b0; sel_b2a = 1'b0; settle();
    a_ext_en = 1'b1; a_ext = 8'h5C; en_a2b = 1'b1; settle();
    check("R9 B from A", b_bus, 8'hA3);
    a_ext_en = 1'b0; en_b2a_n = 1'b0; settle();
    check("R9 A held", a_bus, 8'h5C);
    repeat (4) begin @(negedge clk); settle(); end
    check("R9 A still held", a_bus, 8'h5C);
    check("R9 B still held", b_bus, 8'hA3);
    en_a2b = 1'b0; en_b2a_n = 1'b1; settle();
  endtask

  initial begin
    t_reset();
    t_a2b_live();
    t_a2b_stored();
    t_b2a();
    t_capture_parked();
    t_hold();
    check("R9 no bus contention", n_clash[W-1:0], 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule